// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block is the per-endpoint decision stage of a USB device serial engine. Each cycle it may receive one decoded token event: the packet identifier, the byte count of the data stage, a data-valid (CRC good) bit and the data toggle carried by the PID. From the endpoint's 4-bit operating mode it picks the handshake to send back. It also decides whether the toggle and count registers take the new values, which status flags get set, and whether the mode field is cleared. It then pulses the endpoint interrupt.

Firmware reaches the endpoint through two 8-bit registers: a mode/status register and a count/toggle register. After the engine commits a transaction, both registers are locked and firmware writes to them are dropped. Reading the mode/status register releases the lock. The SETUP flag is outside this protection, because the engine sets it on every SETUP it takes, locked or not. Token events carry only a valid bit and there is no back-pressure: the bus timing cannot be stalled, so a new event may arrive on any cycle, including back to back.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset both registers read 0x00, resp_valid and ep_irq are low, and the registers are unlocked. Register layouts:
  - mode/status (fw_sel=0) is {SETUP, IN, OUT, ACK, mode[3:0]}.
  - count/toggle (fw_sel=1) is {toggle, 3'b0, count[3:0]}.
- R2: A SETUP (tok_pid=2) in any mode from 1 to 7 is accepted. If its count is at most 10 and its data is valid:
  - the response is ACK (resp_code=1);
  - count and toggle take the token's values;
  - the SETUP and ACK flags are set and the mode field is cleared to 0.
- R3: An accepted SETUP whose count is above 10, or whose data is invalid, is junk. It gets no response (code 0) and the ACK flag stays clear. Count, toggle and the SETUP flag are still updated, the mode field is kept, and an interrupt is raised.
- R4: In Disabled mode (0), and in any mode above 7, every OUT (pid 0), IN (pid 1) and SETUP token gets code 0. Nothing changes and no interrupt is raised.
- R5: In NAK mode (1), IN and OUT get NAK (code 2). The matching IN or OUT flag is set and an interrupt is raised. Count and toggle do not change.
- R6: In STALL mode (2), IN and OUT get STALL (code 3), set the matching flag and raise an interrupt. In Ignore mode (3) they get code 0 and no interrupt.
- R7: Control-write modes:
  - In mode 4, an OUT with count at most 10 and valid data gets ACK and updates count and toggle. It sets the OUT and ACK flags and raises an interrupt.
  - In mode 4, any other OUT gets code 0 and no interrupt.
  - In mode 5, an OUT gets NAK and sets the OUT flag.
  - In both modes, an IN (premature status) gets a zero-length packet (code 4) and sets the IN flag.
- R8: In control-read modes (6 and 7), an OUT status stage is judged by its count and data:
  - With count exactly 2 and valid data, it gets ACK, updates count and toggle, and sets the OUT and ACK flags.
  - Any other OUT gets STALL, sets only the OUT flag, and leaves count and toggle alone.
- R9: In mode 6, an IN gets a data packet (code 5). In mode 7, an IN gets NAK. Either way the IN flag is set and an interrupt is raised.
- R10: While locked, firmware writes to either register are ignored. A read of the count/toggle register keeps the lock. A read of the mode/status register releases it, and a later write then takes effect.
- R11: A SETUP that arrives while locked is still processed in full. It sets the SETUP flag and leaves the registers locked.
- R12: resp_valid pulses on the clock edge that captures a token event. ep_irq pulses for one cycle on the following edge, and only for token events that raise an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token event present this cycle |
| tok_pid | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 no event |
| tok_cnt | input | 4 | Received data byte count |
| tok_dval | input | 1 | Data stage CRC good |
| tok_tog | input | 1 | Data toggle carried by the PID |
| resp_valid | output | 1 | Handshake decision valid |
| resp_code | output | 3 | 0 none, 1 ACK, 2 NAK, 3 STALL, 4 zero-length data, 5 data |
| ep_irq | output | 1 | Endpoint interrupt pulse |
| fw_sel | input | 1 | 0 mode/status, 1 count/toggle |
| fw_wr | input | 1 | Firmware write strobe |
| fw_rd | input | 1 | Firmware read strobe |
| fw_wdata | input | 8 | Firmware write data |
| fw_rdata | output | 8 | Selected register contents |

## Verification
Each mode is driven with each token type, so a fault that sends one mode down another mode's row shows up as a wrong response code or flag set.

The count and data-valid inputs are swept across their edges:
- SETUP at 8 versus 12 bytes, and with bad CRC;
- control-read status at 2 versus 3 bytes, and 2 bytes with bad CRC;
- control-write OUT at 12 bytes.

These separate the ACK path from the junk and STALL paths.

Lock sequences alternate writes, count-register reads and mode-register reads, which tells a missing lock apart from one that releases on the wrong register. A SETUP sent into a locked endpoint shows that the flag update bypasses the lock.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  typedef enum logic [1:0] {
    PID_OUT   = 2'd0,
    PID_IN    = 2'd1,
    PID_SETUP = 2'd2,
    PID_NONE  = 2'd3
  } pid_e;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_ZLP   = 3'd4,
    RSP_DATA  = 3'd5
  } rsp_e;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_OFF   = 4'd0;
  localparam logic [MODE_W-1:0] MD_NAK   = 4'd1;
  localparam logic [MODE_W-1:0] MD_STALL = 4'd2;
  localparam logic [MODE_W-1:0] MD_IGN   = 4'd3;
  localparam logic [MODE_W-1:0] MD_CW    = 4'd4;
  localparam logic [MODE_W-1:0] MD_CWN   = 4'd5;
  localparam logic [MODE_W-1:0] MD_CR    = 4'd6;
  localparam logic [MODE_W-1:0] MD_CRN   = 4'd7;

endpackage

// File: rtl/usb_ep_decide.sv
module usb_ep_decide
  import usb_ep_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int SETUP_MAX  = 10,
  parameter int STATUS_CNT = 2
) (
  input  pid_e              pid,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              dval,
  input  logic [MODE_W-1:0] mode,
  output rsp_e              rsp,
  output logic              upd_data,
  output logic              set_setup,
  output logic              set_in,
  output logic              set_out,
  output logic              set_ack,
  output logic              clr_mode,
  output logic              irq
);

  localparam logic [CNT_W-1:0] DATA_MAX = CNT_W'(SETUP_MAX);
  localparam logic [CNT_W-1:0] STAT_LEN = CNT_W'(STATUS_CNT);

  logic in_tok, out_tok, fits, status_ok, live;

  assign in_tok    = (pid == PID_IN);
  assign out_tok   = (pid == PID_OUT);
  assign fits      = (cnt <= DATA_MAX) && dval;
  assign status_ok = (cnt == STAT_LEN) && dval;
  assign live      = (mode != MD_OFF) && (mode <= MD_CRN);

  always_comb begin
    rsp       = RSP_NONE;
    upd_data  = 1'b0;
    set_setup = 1'b0;
    set_in    = 1'b0;
    set_out   = 1'b0;
    set_ack   = 1'b0;
    clr_mode  = 1'b0;
    irq       = 1'b0;
    if (pid == PID_SETUP) begin
      if (live) begin
        upd_data  = 1'b1;
        set_setup = 1'b1;
        irq       = 1'b1;
        if (fits) begin
          rsp      = RSP_ACK;
          set_ack  = 1'b1;
          clr_mode = 1'b1;
        end
      end
    end else if (in_tok || out_tok) begin
      case (mode)
        MD_NAK, MD_STALL: begin
          rsp     = (mode == MD_NAK) ? RSP_NAK : RSP_STALL;
          set_in  = in_tok;
          set_out = out_tok;
          irq     = 1'b1;
        end
        MD_CW, MD_CWN: begin
          if (in_tok) begin
            rsp    = RSP_ZLP;
            set_in = 1'b1;
            irq    = 1'b1;
          end else if (mode == MD_CWN) begin
            rsp     = RSP_NAK;
            set_out = 1'b1;
            irq     = 1'b1;
          end else if (fits) begin
            rsp      = RSP_ACK;
            upd_data = 1'b1;
            set_out  = 1'b1;
            set_ack  = 1'b1;
            irq      = 1'b1;
          end
        end
        MD_CR, MD_CRN: begin
          irq = 1'b1;
          if (in_tok) begin
            rsp    = (mode == MD_CR) ? RSP_DATA : RSP_NAK;
            set_in = 1'b1;
          end else if (status_ok) begin
            rsp      = RSP_ACK;
            upd_data = 1'b1;
            set_out  = 1'b1;
            set_ack  = 1'b1;
          end else begin
            rsp     = RSP_STALL;
            set_out = 1'b1;
          end
        end
        default: rsp = RSP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/usb_ep_regs.sv
module usb_ep_regs
  import usb_ep_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng,
  input  logic              upd_data,
  input  logic              set_setup,
  input  logic              set_in,
  input  logic              set_out,
  input  logic              set_ack,
  input  logic              clr_mode,
  input  logic [CNT_W-1:0]  tok_cnt,
  input  logic              tok_tog,
  input  logic              fw_sel,
  input  logic              fw_wr,
  input  logic              fw_rd,
  input  logic [7:0]        fw_wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              tog_q,
  output logic              setup_f,
  output logic              locked,
  output logic [7:0]        fw_rdata
);

  localparam int PAD_W = 7 - CNT_W;

  logic in_f, out_f, ack_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MD_OFF;
      cnt_q   <= '0;
      tog_q   <= 1'b0;
      setup_f <= 1'b0;
      in_f    <= 1'b0;
      out_f   <= 1'b0;
      ack_f   <= 1'b0;
      locked  <= 1'b0;
    end else if (eng) begin
      if (upd_data) begin
        cnt_q <= tok_cnt;
        tog_q <= tok_tog;
      end
      if (set_setup) setup_f <= 1'b1;
      if (set_in)    in_f    <= 1'b1;
      if (set_out)   out_f   <= 1'b1;
      if (set_ack)   ack_f   <= 1'b1;
      if (clr_mode)  mode_q  <= MD_OFF;
      locked <= 1'b1;
    end else begin
      if (fw_wr && !locked) begin
        if (!fw_sel) begin
          {setup_f, in_f, out_f, ack_f, mode_q} <= fw_wdata;
        end else begin
          tog_q <= fw_wdata[7];
          cnt_q <= fw_wdata[CNT_W-1:0];
        end
      end
      if (fw_rd && !fw_sel) locked <= 1'b0;
    end
  end

  assign fw_rdata = fw_sel ? {tog_q, {PAD_W{1'b0}}, cnt_q}
                           : {setup_f, in_f, out_f, ack_f, mode_q};

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usb_ep_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int SETUP_MAX  = 10,
  parameter int STATUS_CNT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  input  logic [1:0]       tok_pid,
  input  logic [CNT_W-1:0] tok_cnt,
  input  logic             tok_dval,
  input  logic             tok_tog,
  output logic             resp_valid,
  output logic [2:0]       resp_code,
  output logic             ep_irq,
  input  logic             fw_sel,
  input  logic             fw_wr,
  input  logic             fw_rd,
  input  logic [7:0]       fw_wdata,
  output logic [7:0]       fw_rdata
);

  pid_e              pid;
  rsp_e              rsp;
  logic              upd_data, set_setup, set_in, set_out, set_ack, clr_mode, irq;
  logic              event_ok, eng, irq_pend;
  logic [MODE_W-1:0] mode_cur;
  logic [CNT_W-1:0]  cnt_cur;
  logic              tog_cur, setup_f, locked;

  assign pid      = pid_e'(tok_pid);
  assign event_ok = tok_valid && (pid != PID_NONE);
  assign eng      = event_ok && irq;

  usb_ep_decide #(
    .CNT_W(CNT_W), .SETUP_MAX(SETUP_MAX), .STATUS_CNT(STATUS_CNT)
  ) decide_i (
    .pid(pid), .cnt(tok_cnt), .dval(tok_dval), .mode(mode_cur),
    .rsp(rsp), .upd_data(upd_data), .set_setup(set_setup), .set_in(set_in),
    .set_out(set_out), .set_ack(set_ack), .clr_mode(clr_mode), .irq(irq)
  );

  usb_ep_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .eng(eng), .upd_data(upd_data),
    .set_setup(set_setup), .set_in(set_in), .set_out(set_out),
    .set_ack(set_ack), .clr_mode(clr_mode), .tok_cnt(tok_cnt),
    .tok_tog(tok_tog), .fw_sel(fw_sel), .fw_wr(fw_wr), .fw_rd(fw_rd),
    .fw_wdata(fw_wdata), .mode_q(mode_cur), .cnt_q(cnt_cur), .tog_q(tog_cur),
    .setup_f(setup_f), .locked(locked), .fw_rdata(fw_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_code  <= RSP_NONE;
      irq_pend   <= 1'b0;
      ep_irq     <= 1'b0;
    end else begin
      resp_valid <= event_ok;
      resp_code  <= event_ok ? rsp : RSP_NONE;
      irq_pend   <= eng;
      ep_irq     <= irq_pend;
    end
  end

endmodule

// File: rtl/usb_ep_handshake_chk.sv
module usb_ep_handshake_chk
  import usb_ep_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SETUP_MAX = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic [1:0]        tok_pid,
  input logic [CNT_W-1:0]  tok_cnt,
  input logic              tok_dval,
  input logic              fw_wr,
  input logic              resp_valid,
  input logic [2:0]        resp_code,
  input logic              ep_irq,
  input logic [MODE_W-1:0] mode_cur,
  input logic [CNT_W-1:0]  cnt_cur,
  input logic              tog_cur,
  input logic              setup_f,
  input logic              locked
);

  logic real_tok, live_mode;
  assign real_tok  = tok_valid && (tok_pid != PID_NONE);
  assign live_mode = (mode_cur != MD_OFF) && (mode_cur <= MD_CRN);

  AST_IRQ_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> $past(resp_valid)); // R12

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    real_tok && !live_mode |=> resp_code == RSP_NONE); // R4

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    locked && fw_wr && !tok_valid |=> $stable(mode_cur) && $stable(cnt_cur)); // R10

  AST_SETUP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_pid == PID_SETUP && live_mode && tok_dval
    && (int'(tok_cnt) <= SETUP_MAX)
    |=> mode_cur == MD_OFF && setup_f && resp_code == RSP_ACK); // R2

  AST_NAK_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && (tok_pid == PID_IN || tok_pid == PID_OUT) && mode_cur == MD_NAK && !fw_wr
    |=> resp_code == RSP_NAK && $stable(tog_cur) && $stable(cnt_cur)); // R5

  AST_SETUP_PAST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_pid == PID_SETUP && locked && live_mode
    |=> setup_f && locked); // R11

endmodule

bind usb_ep_handshake usb_ep_handshake_chk #(
  .CNT_W(CNT_W), .SETUP_MAX(SETUP_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid),
  .tok_cnt(tok_cnt), .tok_dval(tok_dval), .fw_wr(fw_wr),
  .resp_valid(resp_valid), .resp_code(resp_code), .ep_irq(ep_irq),
  .mode_cur(mode_cur), .cnt_cur(cnt_cur), .tog_cur(tog_cur),
  .setup_f(setup_f), .locked(locked)
);

// File: tb/usb_ep_handshake_tb.sv
module usb_ep_handshake_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_pid = 2'd3;
  logic [3:0] tok_cnt = 4'd0;
  logic       tok_dval = 1'b0;
  logic       tok_tog = 1'b0;
  logic       resp_valid;
  logic [2:0] resp_code;
  logic       ep_irq;
  logic       fw_sel = 1'b0;
  logic       fw_wr = 1'b0;
  logic       fw_rd = 1'b0;
  logic [7:0] fw_wdata = 8'h00;
  logic [7:0] fw_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_handshake dut_i (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid),
    .tok_cnt(tok_cnt), .tok_dval(tok_dval), .tok_tog(tok_tog),
    .resp_valid(resp_valid), .resp_code(resp_code), .ep_irq(ep_irq),
    .fw_sel(fw_sel), .fw_wr(fw_wr), .fw_rd(fw_rd),
    .fw_wdata(fw_wdata), .fw_rdata(fw_rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic peek(input logic sel, output logic [7:0] val);
    fw_sel = sel;
    #1 val = fw_rdata;
  endtask

  task automatic fw_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    fw_sel = sel; fw_wdata = d; fw_wr = 1'b1;
    @(negedge clk);
    fw_wr = 1'b0;
  endtask

  task automatic fw_read(input logic sel);
    @(negedge clk);
    fw_sel = sel; fw_rd = 1'b1;
    @(negedge clk);
    fw_rd = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    fw_read(1'b0);
    fw_write(1'b0, {4'b0000, m});
  endtask

  // Drives one token; returns response code, the irq seen with the response
  // and the irq seen one cycle later.
  task automatic xfer(input logic [1:0] pid, input logic [3:0] cnt,
                      input logic dval, input logic tog,
                      output logic [2:0] rsp, output logic irq_early,
                      output logic irq_late);
    @(negedge clk);
    tok_valid = 1'b1; tok_pid = pid; tok_cnt = cnt; tok_dval = dval; tok_tog = tog;
    @(negedge clk);
    tok_valid = 1'b0; tok_pid = 2'd3;
    check("R12", "resp_valid", {7'b0, resp_valid}, 8'h01);
    rsp = resp_code;
    irq_early = ep_irq;
    @(negedge clk);
    irq_late = ep_irq;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(1'b0, v); check("R1", "mode reg", v, 8'h00);
    peek(1'b1, v); check("R1", "count reg", v, 8'h00);
    check("R1", "resp_valid", {7'b0, resp_valid}, 8'h00);
    check("R1", "ep_irq", {7'b0, ep_irq}, 8'h00);
    fw_write(1'b0, 8'h01);
    peek(1'b0, v); check("R1", "unlocked write", v, 8'h01);
  endtask

  task automatic t_setup_good();
    logic [2:0] r; logic ie, il; logic [7:0] v;
    set_mode(4'd4);
    xfer(2'd2, 4'd8, 1'b1, 1'b1, r, ie, il);
    check("R2", "setup rsp", {5'b0, r}, 8'h01);
    check("R12", "irq not early", {7'b0, ie}, 8'h00);
    check("R12", "irq late", {7'b0, il}, 8'h01);
    peek(1'b0, v); check("R2", "mode reg", v, 8'h90);
    peek(1'b1, v); check("R2", "count reg", v, 8'h88);
    @(negedge clk);
    check("R12", "irq one cycle", {7'b0, ep_irq}, 8'h00);
  endtask

  task automatic t_setup_junk();
    logic [2:0] r; logic ie, il; logic [7:0] v;
    set_mode(4'd4);
    xfer(2'd2, 4'd12, 1'b1, 1'b0, r, ie, il);
    check("R3", "oversize rsp", {5'b0, r}, 8'h00);
    check("R3", "oversize irq", {7'b0, il}, 8'h01);
    peek(1'b0, v); check("R3", "oversize mode reg", v, 8'h84);
    peek(1'b1, v); check("R3", "oversize count", v, 8'h0C);
    set_mode(4'd4);
    xfer(2'd2, 4'd5, 1'b0, 1'b1, r, ie, il);
    check("R3", "bad crc rsp", {5'b0, r}, 8'h00);
    peek(1'b0, v); check("R3", "bad crc mode reg", v, 8'h84);
    peek(1'b1, v); check("R3", "bad crc count", v, 8'h85);
  endtask

  task automatic t_disabled();
    logic [2:0] r; logic ie, il; logic [7:0] v;
    set_mode(4'd0);
    for (int p = 0; p < 3; p++) begin
      xfer(2'(p), 4'd2, 1'b1, 1'b1, r, ie, il);
      check("R4", "off rsp", {5'b0, r}, 8'h00);
      check("R4", "off irq", {7'b0, il}, 8'h00);
    end
    peek(1'b0, v); check("R4", "off mode reg", v, 8'h00);
    set_mode(4'd9);
    xfer(2'd0, 4'd2, 1'b1, 1'b1, r, ie, il);
    check("R4", "mode9 rsp", {5'b0, r}, 8'h00);
    check("R4", "mode9 irq", {7'b0, il}, 8'h00);
    peek(1'b0, v); check("R4", "mode9 reg", v, 8'h09);
  endtask

  task automatic t_nak();
    logic [2:0] r; logic ie, il; logic [7:0] v;
    set_mode(4'd1);
    fw_write(1'b1, 8'h83);
    xfer(2'd1, 4'd9, 1'b1, 1'b0, r, ie, il);
    check("R5", "in nak", {5'b0, r}, 8'h02);
    check("R5", "in irq", {7'b0, il}, 8'h01);
    peek(1'b0, v); check("R5", "in flag", v, 8'h41);
    peek(1'b1, v); check("R5", "count kept", v, 8'h83);
    fw_read(1'b0);
    xfer(2'd0, 4'd4, 1'b1, 1'b0, r, ie, il);
    check("R5", "out nak", {5'b0, r}, 8'h02);
    peek(1'b0, v); check("R5", "out flag", v, 8'h61);
  endtask

  task automatic t_stall_ign();
    logic [2:0] r; logic ie, il; logic [7:0] v;
    set_mode(4'd2);
    xfer(2'd1, 4'd0, 1'b1, 1'b0, r, ie, il);
    check("R6", "stall rsp", {5'b0, r}, 8'h03);
    check("R6", "stall irq", {7'b0, il}, 8'h01);
    peek(1'b0, v); check("R6", "stall flag", v, 8'h42);
    set_mode(4'd3);
    xfer(2'd0, 4'd0, 1'b1, 1'b0, r, ie, il);
    check("R6", "ignore rsp", {5'b0, r}, 8'h00);
    check("R6", "ignore irq", {7'b0, il}, 8'h00);
    peek(1'b0, v); check("R6", "ignore reg", v, 8'h03);
  endtask

  task automatic t_ctrl_write();
    logic [2:0] r; logic ie, il; logic [7:0] v;
    set_mode(4'd4);
    xfer(2'd0, 4'd6, 1'b1, 1'b1, r, ie, il);
    check("R7", "out ack", {5'b0, r}, 8'h01);
    peek(1'b0, v); check("R7", "out flags", v, 8'h34);
    peek(1'b1, v); check("R7", "out count", v, 8'h86);
    fw_read(1'b0);
    xfer(2'd1, 4'd0, 1'b1, 1'b0, r, ie, il);
    check("R7", "premature in zlp", {5'b0, r}, 8'h04);
    peek(1'b0, v); check("R7", "in flag", v, 8'h74);
    set_mode(4'd4);
    xfer(2'd0, 4'd12, 1'b1, 1'b0, r, ie, il);
    check("R7", "oversize out rsp", {5'b0, r}, 8'h00);
    check("R7", "oversize out irq", {7'b0, il}, 8'h00);
    set_mode(4'd5);
    xfer(2'd0, 4'd3, 1'b1, 1'b0, r, ie, il);
    check("R7", "cwn out nak", {5'b0, r}, 8'h02);
    peek(1'b0, v); check("R7", "cwn out flag", v, 8'h25);
    fw_read(1'b0);
    xfer(2'd1, 4'd0, 1'b1, 1'b0, r, ie, il);
    check("R7", "cwn in zlp", {5'b0, r}, 8'h04);
  endtask

  task automatic t_ctrl_read();
    logic [2:0] r; logic ie, il; logic [7:0] v;
    set_mode(4'd6);
    fw_write(1'b1, 8'h00);
    xfer(2'd0, 4'd2, 1'b1, 1'b1, r, ie, il);
    check("R8", "status ack", {5'b0, r}, 8'h01);
    peek(1'b0, v); check("R8", "status flags", v, 8'h36);
    peek(1'b1, v); check("R8", "status count", v, 8'h82);
    set_mode(4'd6);
    xfer(2'd0, 4'd3, 1'b1, 1'b0, r, ie, il);
    check("R8", "count3 stall", {5'b0, r}, 8'h03);
    peek(1'b0, v); check("R8", "count3 flags", v, 8'h26);
    peek(1'b1, v); check("R8", "count3 count kept", v, 8'h82);
    set_mode(4'd6);
    xfer(2'd0, 4'd2, 1'b0, 1'b0, r, ie, il);
    check("R8", "bad crc stall", {5'b0, r}, 8'h03);
  endtask

  task automatic t_ctrl_read_in();
    logic [2:0] r; logic ie, il; logic [7:0] v;
    set_mode(4'd6);
    xfer(2'd1, 4'd0, 1'b1, 1'b0, r, ie, il);
    check("R9", "in data", {5'b0, r}, 8'h05);
    check("R9", "in irq", {7'b0, il}, 8'h01);
    peek(1'b0, v); check("R9", "in flag", v, 8'h46);
    set_mode(4'd7);
    xfer(2'd1, 4'd0, 1'b1, 1'b0, r, ie, il);
    check("R9", "crn in nak", {5'b0, r}, 8'h02);
    peek(1'b0, v); check("R9", "crn flag", v, 8'h47);
  endtask

  task automatic t_lock();
    logic [2:0] r; logic ie, il; logic [7:0] v, c0;
    set_mode(4'd1);
    xfer(2'd1, 4'd0, 1'b1, 1'b0, r, ie, il);
    peek(1'b1, c0);
    fw_write(1'b0, 8'h04);
    peek(1'b0, v); check("R10", "locked mode write", v, 8'h41);
    fw_write(1'b1, 8'h0F);
    peek(1'b1, v); check("R10", "locked count write", v, c0);
    fw_read(1'b1);
    fw_write(1'b0, 8'h04);
    peek(1'b0, v); check("R10", "count read keeps lock", v, 8'h41);
    fw_read(1'b0);
    fw_write(1'b0, 8'h04);
    peek(1'b0, v); check("R10", "write after unlock", v, 8'h04);
  endtask

  task automatic t_setup_locked();
    logic [2:0] r; logic ie, il; logic [7:0] v;
    set_mode(4'd1);
    xfer(2'd1, 4'd0, 1'b1, 1'b0, r, ie, il);
    xfer(2'd2, 4'd4, 1'b1, 1'b0, r, ie, il);
    check("R11", "setup rsp", {5'b0, r}, 8'h01);
    peek(1'b0, v); check("R11", "setup flag", v, 8'hD0);
    peek(1'b1, v); check("R11", "setup count", v, 8'h04);
    fw_write(1'b0, 8'h01);
    peek(1'b0, v); check("R11", "still locked", v, 8'hD0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup_good();
    t_setup_junk();
    t_disabled();
    t_nak();
    t_stall_ign();
    t_ctrl_write();
    t_ctrl_read();
    t_ctrl_read_in();
    t_lock();
    t_setup_locked();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule